// File: doc/BRIEF.md
# Predicated Tile Row Accumulator

This block holds a square matrix store of `VBYTES` rows, each `VBYTES` bytes wide. It adds one source vector into a tile of that store. A tile has either 32-bit or 64-bit elements. The tiles are interleaved through the store, so tile row `r` of tile `t` with an element size of `E` bytes sits at store row `t + r*E`.

There are two accumulate modes:

- **Horizontal mode:** each selected tile row takes the vector element by element.
- **Vertical mode:** tile row `r` takes the single element `vector[r]` on every selected column.

A row predicate and a column predicate both gate every element update. An element is written only when both bits are set.

A command is accepted with a one-cycle `start_i` pulse. The unit then walks the tile one row per cycle, doing a read-modify-write of each row. It raises `done_o` for one cycle after the last row. The store can be read at any time through a combinational read port.

Top module: `tile_acc_unit`

## Requirements
- R1: With `vert_i`=0, for every tile row `r` and column `c` whose row and column predicate bits are both set, element `c` of that row becomes `old + vec[c]`. Element `j` occupies bits `[j*EW +: EW]` of a row and of `vec_i`.
- R2: With `vert_i`=1, for every tile row `r` and column `c` whose predicate bits are both set, element `c` of that row becomes `old + vec[r]`.
- R3: A tile row whose row predicate bit is clear keeps all its bits unchanged.
- R4: Element size is selected by `wide_i`: 0 means 32-bit, 1 means 64-bit. Element `j` uses predicate bit `j*4` for 32-bit elements and bit `j*8` for 64-bit elements. All other predicate bits have no effect. A column whose bit is clear keeps its value.
- R5: Tile row `r` of tile `t` is store row `t + r*E`, where `E` is 4 or 8. The tile number is taken modulo `E`, that is `tile_i[1:0]` for 32-bit and `tile_i[2:0]` for 64-bit. Store rows outside the addressed tile are unchanged.
- R6: Addition wraps modulo 2^EW. There is no saturation and no carry between elements.
- R7: `start_i` sampled high while idle is accepted at that clock edge. `busy_o` is then high for `N` cycles, one row per cycle, where `N` = `VBYTES/E`. `done_o` is high for exactly one cycle, `N+1` cycles after the accepting edge.
- R8: `start_i` while `busy_o` is high is ignored. Its operands neither alter the running command nor start a second one.
- R9: Reset is synchronous and active low. It clears every store row to zero and drives `busy_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command strobe |
| vert_i | input | 1 | 0 horizontal, 1 vertical broadcast |
| wide_i | input | 1 | 0 for 32-bit elements, 1 for 64-bit |
| tile_i | input | 3 | Tile number |
| vec_i | input | VBYTES*8 | Source vector |
| rowp_i | input | VBYTES | Row predicate |
| colp_i | input | VBYTES | Column predicate |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_row_i | input | log2(VBYTES) | Store row to read |
| rd_data_o | output | VBYTES*8 | Contents of the addressed store row |

## Verification
A wrong row counter or a wrong address computation writes the update into a store row outside the tile, or into the wrong tile row. That shows up on the read port as soon as `done_o` rises. A fault in the command capture shows the same way: operands taken in mid-run would change the sums the bench reads back.

A fault in the predicate striding or in the lane enables changes the value of specific elements. Every store row is therefore read back after every command, covering both modes and both element sizes.

A sequencing fault moves the `done_o` pulse away from cycle `N+1`, and the bench measures that cycle count directly.

// File: rtl/tile_acc_pkg.sv
// Package: shared constants and helpers for the tile row accumulator.
// Assumes the row width is at least 16 bytes.
package tile_acc_pkg;

    localparam int EB32 = 4;   // bytes per narrow element
    localparam int EB64 = 8;   // bytes per wide element

    // Number of tile rows for a given element size and row width.
    function automatic int rows_of(input logic wide, input int vbytes);
        return wide ? vbytes / EB64 : vbytes / EB32;
    endfunction

endpackage

// File: rtl/tile_acc_seq.sv
// Sequencer: accepts a command while idle, steps a row counter once per
// cycle, and emits a single-cycle done pulse after the last row.
// Assumes wide_i holds the captured element size during the whole run.
module tile_acc_seq #(
    parameter int VBYTES = 16,
    localparam int RW = $clog2(VBYTES / 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wide_i,
    output logic          accept_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [RW-1:0] row_o
);
    import tile_acc_pkg::*;

    logic [RW-1:0] last_row;

    // Final row index for the captured element size.
    always_comb last_row = RW'(rows_of(wide_i, VBYTES) - 1);

    // A command is taken only while idle.
    always_comb accept_o = start_i && !busy_o;

    // Row counter, busy and done state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            row_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                busy_o <= 1'b1;
                row_o  <= '0;
            end else if (busy_o) begin
                if (row_o == last_row) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    row_o <= row_o + 1'b1;
                end
            end
        end
    end

    // R7: done is a single-cycle pulse.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done follows directly on the final busy cycle.
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7: the counter never passes the last tile row.
    a_r7_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> row_o <= last_row);

endmodule

// File: rtl/tile_acc_rowcalc.sv
// Row calculator: forms the updated store row from the old row, the source
// vector and the predicates, for both modes and both element sizes.
// Assumes row_i is below the tile row count of the chosen size.
module tile_acc_rowcalc #(
    parameter int VBYTES = 16,
    localparam int W   = VBYTES * 8,
    localparam int N32 = VBYTES / 4,
    localparam int N64 = VBYTES / 8,
    localparam int RW  = $clog2(N32)
) (
    input  logic [W-1:0]      old_i,
    input  logic [W-1:0]      vec_i,
    input  logic [VBYTES-1:0] colp_i,
    input  logic              row_en_i,
    input  logic [RW-1:0]     row_i,
    input  logic              vert_i,
    input  logic              wide_i,
    output logic [W-1:0]      new_o
);
    logic [W-1:0]  res32;
    logic [W-1:0]  res64;
    logic [31:0]   bcast32;
    logic [63:0]   bcast64;

    // Scalar chosen for the vertical broadcast.
    always_comb begin
        bcast32 = vec_i[32*row_i +: 32];
        bcast64 = vec_i[64*row_i[RW-2:0] +: 64];
    end

    // One adder per 32-bit lane.
    for (genvar j = 0; j < N32; j++) begin : g_l32
        logic [31:0] add32;
        always_comb begin
            add32 = vert_i ? bcast32 : vec_i[32*j +: 32];
            res32[32*j +: 32] = (row_en_i && colp_i[4*j])
                ? old_i[32*j +: 32] + add32 : old_i[32*j +: 32];
        end
    end

    // One adder per 64-bit lane.
    for (genvar j = 0; j < N64; j++) begin : g_l64
        logic [63:0] add64;
        always_comb begin
            add64 = vert_i ? bcast64 : vec_i[64*j +: 64];
            res64[64*j +: 64] = (row_en_i && colp_i[8*j])
                ? old_i[64*j +: 64] + add64 : old_i[64*j +: 64];
        end
    end

    // Select the result for the element size.
    always_comb new_o = wide_i ? res64 : res32;

endmodule

// File: rtl/tile_acc_store.sv
// Matrix store: VBYTES rows of VBYTES bytes, one write port and two
// combinational read ports. Synchronous reset clears every row.
module tile_acc_store #(
    parameter int VBYTES = 16,
    localparam int W  = VBYTES * 8,
    localparam int AW = $clog2(VBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [W-1:0]  rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_b_o
);
    logic [W-1:0] mem [VBYTES];

    // Row storage with reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < VBYTES; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Read ports.
    always_comb begin
        rdata_a_o = mem[raddr_a_i];
        rdata_b_o = mem[raddr_b_i];
    end

endmodule

// File: rtl/tile_acc_unit.sv
// Top: captures a command, walks the addressed tile one row per cycle
// through a read-modify-write of the store, and exposes a read port.
// Assumes VBYTES is a power of two and at least 16.
module tile_acc_unit #(
    parameter int VBYTES = 16,
    localparam int W  = VBYTES * 8,
    localparam int AW = $clog2(VBYTES),
    localparam int RW = $clog2(VBYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              vert_i,
    input  logic              wide_i,
    input  logic [2:0]        tile_i,
    input  logic [W-1:0]      vec_i,
    input  logic [VBYTES-1:0] rowp_i,
    input  logic [VBYTES-1:0] colp_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic [AW-1:0]     rd_row_i,
    output logic [W-1:0]      rd_data_o
);
    logic              accept;
    logic [RW-1:0]     row;
    logic              vert_q, wide_q;
    logic [2:0]        tile_q;
    logic [W-1:0]      vec_q;
    logic [VBYTES-1:0] rowp_q, colp_q;
    logic [AW-1:0]     waddr;
    logic              row_en;
    logic [W-1:0]      old_row, new_row;

    // Command capture on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vert_q <= 1'b0;
            wide_q <= 1'b0;
            tile_q <= '0;
            vec_q  <= '0;
            rowp_q <= '0;
            colp_q <= '0;
        end else if (accept) begin
            vert_q <= vert_i;
            wide_q <= wide_i;
            tile_q <= tile_i;
            vec_q  <= vec_i;
            rowp_q <= rowp_i;
            colp_q <= colp_i;
        end
    end

    // Interleaved store address and row predicate bit for the current row.
    always_comb begin
        if (wide_q) begin
            waddr  = (AW'(row) << 3) | AW'(tile_q);
            row_en = rowp_q[AW'(row) << 3];
        end else begin
            waddr  = (AW'(row) << 2) | AW'(tile_q[1:0]);
            row_en = rowp_q[AW'(row) << 2];
        end
    end

    tile_acc_seq #(.VBYTES(VBYTES)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_q),
        .accept_o(accept), .busy_o(busy_o), .done_o(done_o), .row_o(row)
    );

    tile_acc_rowcalc #(.VBYTES(VBYTES)) calc_i (
        .old_i(old_row), .vec_i(vec_q), .colp_i(colp_q), .row_en_i(row_en),
        .row_i(row), .vert_i(vert_q), .wide_i(wide_q), .new_o(new_row)
    );

    tile_acc_store #(.VBYTES(VBYTES)) store_i (
        .clk(clk), .rst_n(rst_n), .we_i(busy_o), .waddr_i(waddr),
        .wdata_i(new_row), .raddr_a_i(waddr), .rdata_a_o(old_row),
        .raddr_b_i(rd_row_i), .rdata_b_o(rd_data_o)
    );

    // R3: a row with its predicate bit clear is written back unchanged.
    a_r3_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !row_en) |-> new_row == old_row);

    // R8: a start during a run leaves the captured command untouched.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(vec_q) && $stable(tile_q)
                                 && $stable(rowp_q) && $stable(colp_q)
                                 && $stable(vert_q) && $stable(wide_q)));

    // R9: nothing is in progress in the cycle after reset.
    a_r9_idle_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy_o && !done_o));

endmodule

// File: tb/tile_acc_unit_tb.sv
// Bench for tile_acc_unit: a vector table walked by one loop, then
// directed tests for reset, timing, ignored start and wraparound.
module tile_acc_unit_tb_top;
    localparam int VB = 16;
    localparam int W  = VB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, vert_i = 1'b0, wide_i = 1'b0;
    logic [2:0]    tile_i = '0;
    logic [W-1:0]  vec_i = '0;
    logic [VB-1:0] rowp_i = '0, colp_i = '0;
    logic          busy_o, done_o;
    logic [3:0]    rd_row_i = '0;
    logic [W-1:0]  rd_data_o;

    int nchk = 0;
    int nfail = 0;
    logic [W-1:0] model [VB];

    always #10 clk = ~clk;

    tile_acc_unit #(.VBYTES(VB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vert_i(vert_i),
        .wide_i(wide_i), .tile_i(tile_i), .vec_i(vec_i), .rowp_i(rowp_i),
        .colp_i(colp_i), .busy_o(busy_o), .done_o(done_o),
        .rd_row_i(rd_row_i), .rd_data_o(rd_data_o)
    );

    // Vector table: mode, size, tile, vector, row and column predicates.
    localparam int NV = 7;
    localparam logic        TV_VERT [NV] = '{0, 1, 0, 1, 0, 0, 1};
    localparam logic        TV_WIDE [NV] = '{0, 0, 1, 1, 0, 0, 0};
    localparam logic [2:0]  TV_TILE [NV] = '{0, 1, 3, 6, 6, 2, 0};
    localparam logic [15:0] TV_ROWP [NV] = '{16'h1111, 16'h0101, 16'h0101,
        16'h0100, 16'hEEEE, 16'h1111, 16'h1010};
    localparam logic [15:0] TV_COLP [NV] = '{16'h1111, 16'h1011, 16'h0001,
        16'h0101, 16'hFFFF, 16'h1EEE, 16'h0110};
    localparam logic [W-1:0] TV_VEC [NV] = '{
        128'h00000004_00000003_00000002_00000001,
        128'h40000000_30000000_20000000_10000000,
        128'h22222222_22222222_11111111_11111111,
        128'hAAAAAAAA_00000005_12345678_9ABCDEF0,
        128'h01010101_02020202_03030303_04040404,
        128'hFFFFFFFF_00000007_00000008_00000009,
        128'h0000000D_0000000C_0000000B_0000000A};

    // Bench model of one command, built from R1 to R6.
    task automatic model_apply(input logic vt, input logic wd,
                               input logic [2:0] tl, input logic [W-1:0] v,
                               input logic [VB-1:0] rp, input logic [VB-1:0] cp);
        int e = wd ? 8 : 4;
        int n = VB / e;
        int t = int'(tl) % e;
        for (int r = 0; r < n; r++) begin
            int a = t + r * e;
            if (rp[r*e]) begin
                for (int c = 0; c < n; c++) begin
                    if (cp[c*e]) begin
                        if (wd) model[a][64*c +: 64] = model[a][64*c +: 64]
                            + (vt ? v[64*r +: 64] : v[64*c +: 64]);
                        else model[a][32*c +: 32] = model[a][32*c +: 32]
                            + (vt ? v[32*r +: 32] : v[32*c +: 32]);
                    end
                end
            end
        end
    endtask

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all_rows(input string tag);
        for (int i = 0; i < VB; i++) begin
            rd_row_i = 4'(i);
            #1;
            check(tag, rd_data_o, model[i]);
        end
    endtask

    // Issues one command and returns the cycle count until done.
    task automatic run_cmd(input logic vt, input logic wd, input logic [2:0] tl,
                           input logic [W-1:0] v, input logic [VB-1:0] rp,
                           input logic [VB-1:0] cp, output int cyc);
        @(negedge clk);
        vert_i = vt; wide_i = wd; tile_i = tl; vec_i = v;
        rowp_i = rp; colp_i = cp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        model_apply(vt, wd, tl, v, rp, cp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < VB; i++) model[i] = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 nchk, nfail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cyc;
        do_reset();
        @(negedge clk);
        // R9: reset state.
        check("R9 busy", W'(busy_o), '0);
        check("R9 done", W'(done_o), '0);
        check_all_rows("R9 rows");

        // Table walk: R1 R2 R3 R4 R5 across both modes and sizes.
        for (int k = 0; k < NV; k++) begin
            run_cmd(TV_VERT[k], TV_WIDE[k], TV_TILE[k], TV_VEC[k],
                    TV_ROWP[k], TV_COLP[k], cyc);
            check_all_rows("R1 R2 R3 R4 R5 table");
        end

        // R7: timing for 32-bit (4 rows) and 64-bit (2 rows).
        run_cmd(0, 0, 3'd1, {4{32'h1}}, 16'hFFFF, 16'hFFFF, cyc);
        check("R7 cycles 32-bit", W'(cyc), W'(5));
        @(negedge clk);
        check("R7 done one cycle", W'(done_o), '0);
        run_cmd(0, 1, 3'd5, {2{64'h2}}, 16'hFFFF, 16'hFFFF, cyc);
        check("R7 cycles 64-bit", W'(cyc), W'(3));
        check_all_rows("R7 rows");

        // R8: start during a run is ignored.
        @(negedge clk);
        vert_i = 0; wide_i = 0; tile_i = 3'd2; vec_i = {4{32'h11}};
        rowp_i = 16'hFFFF; colp_i = 16'hFFFF; start_i = 1'b1;
        @(negedge clk);
        vert_i = 1; wide_i = 1; tile_i = 3'd7; vec_i = {4{32'h99}};
        rowp_i = 16'hFFFF; colp_i = 16'hFFFF;
        check("R8 busy", W'(busy_o), W'(1));
        @(negedge clk);
        start_i = 1'b0;
        cyc = 2;
        while (!done_o && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        check("R8 cycles", W'(cyc), W'(5));
        model_apply(0, 0, 3'd2, {4{32'h11}}, 16'hFFFF, 16'hFFFF);
        repeat (3) @(negedge clk);
        check("R8 no second run", W'(busy_o), '0);
        check_all_rows("R8 rows");

        // R9: reset during a run clears the store.
        @(negedge clk);
        vec_i = {4{32'h5}}; tile_i = 0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        do_reset();
        @(negedge clk);
        check("R9 mid-run busy", W'(busy_o), '0);
        check_all_rows("R9 mid-run rows");

        // R6: wraparound at the element width, no carry between lanes.
        run_cmd(0, 0, 3'd0, {4{32'h80000000}}, 16'h0001, 16'h0011, cyc);
        run_cmd(0, 0, 3'd0, {4{32'h80000001}}, 16'h0001, 16'h0011, cyc);
        rd_row_i = 4'd0;
        #1;
        check("R6 wrap 32", rd_data_o, 128'h0000_0001_0000_0001);
        run_cmd(0, 1, 3'd1, {2{64'hFFFFFFFF_FFFFFFFF}}, 16'h0001, 16'h0001, cyc);
        run_cmd(0, 1, 3'd1, {2{64'h2}}, 16'h0001, 16'h0001, cyc);
        rd_row_i = 4'd1;
        #1;
        check("R6 wrap 64", rd_data_o, 128'h1);
        check_all_rows("R6 rows");

        finish_run();
    end
endmodule